// File: doc/BRIEF.md
# Staggered Channel Switch Sequencer

This block turns a vector of per-channel on/off bits and a global blanking input into one enable per channel. The switching of the channels is spread out in time so that the supply does not see every load change at once. Channel 0 follows its gated request after a single register stage. Channel n follows its own request a further n step-delays later. The step is given in system-clock cycles on a plain input.

The delay applies in the same way to rising and falling edges. Because of this, each channel is enabled for exactly as many cycles as the blanking input was low, even when blanking returns high before a late channel has turned on. In that case the late channel still turns on, then turns off at its own delayed time. While blanking is high, the gated request of every channel is off, whatever its on/off bit says.

The block is a set of per-channel delay lanes fed by a shared gating stage. A designer sets the step once for a display. The step may also be changed on the fly: any change takes effect at the next clock edge, because every lane keeps a full history of its gated request.

Top module: `staggered_switch_seq`

## Requirements
- R1: While reset is asserted every channel enable is 0; after reset every lane history reads as off.
- R2: The gated request of channel n is `onoff[n] & ~blank`. Channel 0's enable after clock edge k equals its gated request sampled at edge k, with no step delay.
- R3: Channel n's enable after edge k equals its gated request sampled at edge k − n·S, where S is the effective step sampled at edge k. Requests from before reset release read as 0. So channel n turns on n·S cycles after channel 0 when both requests rise together.
- R4: Turn-off is staggered by the same rule: channel n turns off n·S cycles after channel 0 when both requests fall together.
- R5: While blank is 1, all gated requests are 0, so each enable goes to 0 once its own delay has passed, regardless of onoff.
- R6: With onoff held at all ones, a blank-low window of L cycles produces exactly L enabled cycles on every channel, including channels whose delay exceeds L.
- R7: With a step of 0, every channel switches on the same edge as channel 0.
- R8: The effective step is min(step, MAX_STEP). A step input above MAX_STEP (8 by default) behaves as MAX_STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| onoff | input | N_CH (16) | Per-channel on/off request, bit n for channel n |
| blank | input | 1 | Global blanking; 1 forces every gated request off |
| step | input | STEP_W (4) | Stagger step in clock cycles, clamped to MAX_STEP |
| chan_en | output | N_CH (16) | Delayed channel enables, bit n for channel n |

## Verification
Every enable is registered. Channel n's value after edge k is therefore due one edge after its gated request was sampled, plus n times the step in force at edge k. The bench records the gated request and the clamped step at every rising edge. It compares all sixteen enables at the following falling edge against that recorded history, so each result is read exactly when it is due and never while it is changing. Pulse tests also time each channel's rising and falling edge and its on-count against channel 0, which checks the stagger and the equal on-time as intervals rather than only as snapshots.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

  // Number of history stages a lane needs for the largest step.
  function automatic int unsigned lane_depth(int unsigned idx, int unsigned max_step);
    return idx * max_step;
  endfunction

  // Width of a tap index that addresses 0..depth.
  function automatic int unsigned tap_width(int unsigned depth);
    return (depth < 1) ? 1 : $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/stagger_ctrl.sv
module stagger_ctrl #(
  parameter int N_CH     = 16,
  parameter int MAX_STEP = 8,
  parameter int STEP_W   = 4
) (
  input  logic [N_CH-1:0]   onoff,
  input  logic              blank,
  input  logic [STEP_W-1:0] step,
  output logic [N_CH-1:0]   req,
  output logic [STEP_W-1:0] step_eff
);

  localparam logic [STEP_W-1:0] STEP_CAP = STEP_W'(MAX_STEP);

  // Blanking gates every request before it enters the delay lanes, so
  // the on-window of each lane is the blank-low window shifted in time.
  assign req = onoff & ~{N_CH{blank}};

  // Steps above the history depth are held at the deepest tap.
  assign step_eff = (step > STEP_CAP) ? STEP_CAP : step;

endmodule

// File: rtl/stagger_lane.sv
module stagger_lane
  import stagger_pkg::*;
#(
  parameter int IDX      = 0,
  parameter int MAX_STEP = 8,
  parameter int STEP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src,
  input  logic [STEP_W-1:0] step_eff,
  output logic              en_o
);

  localparam int DEPTH = int'(lane_depth(IDX, MAX_STEP));

  generate
    if (DEPTH == 0) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_o <= 1'b0;
        else        en_o <= src;
      end
    end else begin : g_chain
      localparam int TAP_W = int'(tap_width(DEPTH));
      logic [DEPTH:1]   hist;
      logic [DEPTH:0]   taps;
      logic [TAP_W-1:0] tap;

      // taps[m] holds the request sampled m edges before the current one.
      assign taps = {hist, src};
      assign tap  = TAP_W'(IDX * int'(step_eff));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist <= '0;
          en_o <= 1'b0;
        end else begin
          hist <= taps[DEPTH-1:0];
          en_o <= taps[tap];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/staggered_switch_seq.sv
module staggered_switch_seq #(
  parameter int N_CH     = 16,
  parameter int MAX_STEP = 8,
  parameter int STEP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   onoff,
  input  logic              blank,
  input  logic [STEP_W-1:0] step,
  output logic [N_CH-1:0]   chan_en
);

  logic [N_CH-1:0]   req;
  logic [STEP_W-1:0] step_eff;

  stagger_ctrl #(
    .N_CH(N_CH), .MAX_STEP(MAX_STEP), .STEP_W(STEP_W)
  ) u_ctrl (
    .onoff(onoff), .blank(blank), .step(step),
    .req(req), .step_eff(step_eff)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_lane
    stagger_lane #(
      .IDX(n), .MAX_STEP(MAX_STEP), .STEP_W(STEP_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .src(req[n]),
      .step_eff(step_eff), .en_o(chan_en[n])
    );
  end

endmodule

// File: rtl/stagger_seq_checker.sv
module stagger_seq_checker #(
  parameter int N_CH   = 16,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   onoff,
  input logic              blank,
  input logic [STEP_W-1:0] step,
  input logic [N_CH-1:0]   chan_en
);

  // R1: enables are cleared while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (chan_en == '0);
    end
  end

  // R2: channel 0 carries its gated request after one edge
  p_ch0_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> chan_en[0] == $past(onoff[0] & ~blank));

  // R5: blank high leaves channel 0 off on the next cycle
  p_blank_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(blank)) |-> !chan_en[0]);

  // R7: a zero step moves every channel together
  p_step_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step) == '0) |-> chan_en == $past(onoff & ~{N_CH{blank}}));

endmodule

bind staggered_switch_seq stagger_seq_checker #(
  .N_CH(N_CH), .STEP_W(STEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .onoff(onoff), .blank(blank),
  .step(step), .chan_en(chan_en)
);

// File: tb/staggered_switch_seq_test.sv
`timescale 1ns/1ps
module staggered_switch_seq_test;

  localparam int N   = 16;
  localparam int MS  = 8;
  localparam int SW  = 4;
  localparam int HL  = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  onoff = '0;
  logic          blank = 1'b1;
  logic [SW-1:0] step = '0;
  logic [N-1:0]  chan_en;

  int checks = 0;
  int fails  = 0;
  int kc     = 0;
  bit done   = 1'b0;
  string tag = "R1";

  logic [N-1:0] ehist [HL];
  int           shist [HL];

  int on_cnt [N];
  int rise_k [N];
  int fall_k [N];
  logic [N-1:0] prev_en = '0;

  staggered_switch_seq #(.N_CH(N), .MAX_STEP(MS), .STEP_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .onoff(onoff), .blank(blank),
    .step(step), .chan_en(chan_en)
  );

  always #5 clk = ~clk;

  function automatic int clamp(int s);
    return (s > MS) ? MS : s;
  endfunction

  // Record gated request and clamped step at every active edge.
  always @(posedge clk) begin
    if (rst_n) begin
      kc = kc + 1;
      ehist[kc % HL] = onoff & ~{N{blank}};
      shist[kc % HL] = clamp(int'(step));
    end
  end

  function automatic logic [N-1:0] model(int k);
    logic [N-1:0] r = '0;
    for (int n = 0; n < N; n++) begin
      int j = k - n * shist[k % HL];
      r[n] = (j >= 1) ? ehist[j % HL][n] : 1'b0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, kc, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, kc, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (!rst_n) check("R1", chan_en, '0);
    else        check(tag, chan_en, model(kc));
    for (int n = 0; n < N; n++) begin
      if (chan_en[n]) on_cnt[n]++;
      if (chan_en[n] && !prev_en[n] && rise_k[n] < 0) rise_k[n] = kc;
      if (!chan_en[n] && prev_en[n]) fall_k[n] = kc;
    end
    prev_en = chan_en;
  endtask

  task automatic run(int c);
    for (int i = 0; i < c; i++) cyc();
  endtask

  // Blank-low window of len cycles with all channels requested.
  task automatic pulse(int sval, int len, int es, string rtag);
    tag   = rtag;
    blank = 1'b1;
    onoff = '1;
    step  = SW'(sval);
    run(MS * N + 4);
    for (int n = 0; n < N; n++) begin
      on_cnt[n] = 0; rise_k[n] = -1; fall_k[n] = -1;
    end
    blank = 1'b0;
    run(len);
    blank = 1'b1;
    run(MS * N + 4);
    for (int n = 0; n < N; n++) begin
      check_int("R6 on-time", on_cnt[n], len);
      check_int({rtag, " R3 rise offset"}, rise_k[n] - rise_k[0], n * es);
      check_int({rtag, " R4 fall offset"}, fall_k[n] - fall_k[0], n * es);
    end
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240611);
    for (int n = 0; n < N; n++) begin
      on_cnt[n] = 0; rise_k[n] = -1; fall_k[n] = -1;
    end
    // R1: reset holds everything off even with requests present
    onoff = '1;
    blank = 1'b0;
    run(6);
    onoff = '0;
    blank = 1'b1;
    rst_n = 1'b1;
    tag = "R2 R5";
    run(4);
    // R1: first cycles after release read an off history
    check("R1 post-reset", chan_en, '0);

    // R3 R4 R6: late channels turn on after blank has risen again
    pulse(3, 20, 3, "R3");
    // R6: window longer than the whole stagger
    pulse(2, 40, 2, "R6");
    // R7: zero step, all channels on the same edge
    pulse(0, 7, 0, "R7");
    // R8: step above the maximum acts as the maximum
    pulse(12, 15, MS, "R8");

    // R7: zero step with a mixed pattern and blank toggling
    tag = "R7 R5";
    step = '0;
    onoff = 16'hA5C3;
    for (int i = 0; i < 40; i++) begin
      blank = (i % 5) < 2;
      cyc();
    end

    // R2 R3 R5: random requests, blanking and live step changes
    tag = "R3 random";
    for (int i = 0; i < 3000; i++) begin
      if (i % 250 == 0) step = SW'($urandom_range(0, 10));
      if ($urandom_range(0, 9) == 0) onoff = N'($urandom);
      if ($urandom_range(0, 14) == 0) blank = ~blank;
      cyc();
    end

    blank = 1'b1;
    tag = "R5 drain";
    run(MS * N + 4);
    check("R5 all off", chan_en, '0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", kc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule